// File: doc/BRIEF.md
# Bank-to-Bank Block Move Engine

This block copies a run of bytes inside a 24-bit byte-addressed memory space. A one-cycle start pulse captures a request with six parts: a source bank byte, a destination bank byte, a 16-bit source offset, a 16-bit destination offset, a 16-bit count and a direction select. The engine then walks the run one byte at a time on a simple synchronous memory port. For each byte it reads the source location and writes the same value to the destination location. After each byte it steps both offsets and the count. Every byte takes the same fixed number of clock cycles.

The count input holds the number of bytes minus one. A count of 0x0000 moves one byte, and a count of 0xFFFF moves 65536 bytes. The engine stops after the byte on which the count steps from 0x0000 to 0xFFFF. It then raises a one-cycle completion pulse, presents the final offsets and count, and loads its data-bank output with the destination bank. Software should pick the direction by how the two regions overlap. When the destination lies above the source, decrement from the top ends. When it lies below, increment from the bottom ends. Either way the source bytes land in the destination unharmed.

Top module: `block_move_engine`

## Requirements
- R1: After reset, busy, done, mem_rd and mem_wr are 0, and x_out, y_out, cnt_out and dbr_out are all 0.
- R2: A start accepted with count value c moves exactly c+1 bytes. cnt_out steps down by one per byte and reads 0xFFFF at completion.
- R3: Each byte takes exactly 7 clock cycles, so busy stays high for 7*(c+1) cycles. done is high for exactly one cycle, the cycle after busy falls.
- R4: Each byte uses exactly one read cycle and one write cycle. The read addresses {src_bank, X}. The write addresses {dst_bank, Y} two cycles later and carries the byte returned by the read. mem_rdata is valid the cycle after mem_rd. No other memory cycles occur.
- R5: With dir_dec = 0, X and Y each increase by one after every byte. With dir_dec = 1, they each decrease by one. The final offsets are the start offsets plus or minus (c+1), modulo 2^16.
- R6: Offsets wrap from 0xFFFF to 0x0000 (and back) inside their bank. The bank byte on mem_addr[23:16] never changes during a move.
- R7: After a move, the destination bytes equal a byte-by-byte sequential copy. For an overlapping move in the matching direction, the destination holds the original source contents.
- R8: dbr_out takes the destination bank in the same cycle done rises, and it holds its value at all other times.
- R9: A start pulse while busy is 1 is ignored: the running move's addresses, cycle count and results are unchanged.
- R10: mem_rd and mem_wr are never high together, and neither is high while busy is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only when idle |
| dir_dec | input | 1 | 0: offsets increment, 1: offsets decrement |
| src_bank | input | 8 | Source bank byte |
| dst_bank | input | 8 | Destination bank byte |
| x_in | input | 16 | Starting source offset |
| y_in | input | 16 | Starting destination offset |
| cnt_in | input | 16 | Byte count minus one |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |
| x_out | output | 16 | Current or final source offset |
| y_out | output | 16 | Current or final destination offset |
| cnt_out | output | 16 | Current or final count |
| dbr_out | output | 8 | Data bank, set to the destination bank at completion |
| mem_addr | output | 24 | Memory byte address {bank, offset} |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |

## Verification
The properties assume the memory returns read data exactly one cycle after the strobe. They also assume rst is held long enough for the outputs to settle before the first start. The bench's memory model has that fixed single-cycle latency, and it applies reset before any request. Every request and stray start pulse is driven on the falling edge, so start is a clean single-cycle level at the sampling edge. The sweep keeps counts small enough that a move stays well inside the watchdog. It still covers both directions, equal and distinct banks, both offset wraps and both overlap orders.

// File: rtl/blkmv_pkg.sv
package blkmv_pkg;
  // Direction of offset stepping during a move.
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } blkmv_dir_e;
endpackage

// File: rtl/blkmv_phase.sv
// Per-byte phase counter. It decodes the read, capture, write and end-of-byte
// slots from a single small counter that idles at zero.
module blkmv_phase #(
  parameter int STEPS  = 7,
  parameter int RD_LAT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic at_rd,
  output logic at_cap,
  output logic at_wr,
  output logic at_end
);
  localparam int PH_W   = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int CAP_PH = RD_LAT;
  localparam int WR_PH  = RD_LAT + 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(STEPS - 1);

  logic [PH_W-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= '0;
    end else if (!run || ph == LAST_PH) begin
      ph <= '0;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign at_rd  = run && (ph == '0);
  assign at_cap = run && (ph == PH_W'(CAP_PH));
  assign at_wr  = run && (ph == PH_W'(WR_PH));
  assign at_end = run && (ph == LAST_PH);
endmodule

// File: rtl/blkmv_ofs.sv
// 16-bit style wrap-around stepping register. The DOWN_ONLY variant is used
// for the remaining-count register, which always decrements.
module blkmv_ofs #(
  parameter int W         = 16,
  parameter bit DOWN_ONLY = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         down,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  generate
    if (DOWN_ONLY) begin : g_dec
      assign nxt = q - 1'b1;
    end else begin : g_bidir
      assign nxt = down ? (q - 1'b1) : (q + 1'b1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (step) begin
      q <= nxt;
    end
  end
endmodule

// File: rtl/blkmv_port.sv
// Memory port driver: address mux, strobes and the one-byte holding register.
module blkmv_port #(
  parameter int BANK_W = 8,
  parameter int OFS_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    at_rd,
  input  logic                    at_cap,
  input  logic                    at_wr,
  input  logic [BANK_W-1:0]       src_bank,
  input  logic [BANK_W-1:0]       dst_bank,
  input  logic [OFS_W-1:0]        src_ofs,
  input  logic [OFS_W-1:0]        dst_ofs,
  input  logic [DATA_W-1:0]       rdata,
  output logic [BANK_W+OFS_W-1:0] addr,
  output logic                    rd,
  output logic                    wr,
  output logic [DATA_W-1:0]       wdata
);
  logic [DATA_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
    end else if (at_cap) begin
      hold <= rdata;
    end
  end

  assign addr  = at_wr ? {dst_bank, dst_ofs} : {src_bank, src_ofs};
  assign rd    = at_rd;
  assign wr    = at_wr;
  assign wdata = hold;
endmodule

// File: rtl/block_move_engine.sv
module block_move_engine #(
  parameter int OFS_W  = 16,
  parameter int BANK_W = 8,
  parameter int DATA_W = 8,
  parameter int STEPS  = 7,
  parameter int RD_LAT = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    dir_dec,
  input  logic [BANK_W-1:0]       src_bank,
  input  logic [BANK_W-1:0]       dst_bank,
  input  logic [OFS_W-1:0]        x_in,
  input  logic [OFS_W-1:0]        y_in,
  input  logic [OFS_W-1:0]        cnt_in,
  output logic                    busy,
  output logic                    done,
  output logic [OFS_W-1:0]        x_out,
  output logic [OFS_W-1:0]        y_out,
  output logic [OFS_W-1:0]        cnt_out,
  output logic [BANK_W-1:0]       dbr_out,
  output logic [BANK_W+OFS_W-1:0] mem_addr,
  output logic                    mem_rd,
  output logic                    mem_wr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic [DATA_W-1:0]       mem_rdata
);
  import blkmv_pkg::*;

  localparam int ADDR_W = BANK_W + OFS_W;

  logic              busy_q, done_q;
  logic [BANK_W-1:0] sb_q, db_q, dbr_q;
  blkmv_dir_e        dir_q;
  logic              at_rd, at_cap, at_wr, at_end;
  logic              take;
  logic              last_byte;

  assign take      = start && !busy_q;
  assign last_byte = at_end && (cnt_out == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sb_q   <= '0;
      db_q   <= '0;
      dir_q  <= DIR_UP;
      dbr_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        busy_q <= 1'b1;
        sb_q   <= src_bank;
        db_q   <= dst_bank;
        dir_q  <= blkmv_dir_e'(dir_dec);
      end else if (last_byte) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        dbr_q  <= db_q;
      end
    end
  end

  blkmv_phase #(.STEPS(STEPS), .RD_LAT(RD_LAT)) u_phase (
    .clk(clk), .rst(rst), .run(busy_q),
    .at_rd(at_rd), .at_cap(at_cap), .at_wr(at_wr), .at_end(at_end)
  );

  blkmv_ofs #(.W(OFS_W), .DOWN_ONLY(1'b0)) u_xreg (
    .clk(clk), .rst(rst), .load(take), .load_val(x_in),
    .step(at_end), .down(dir_q == DIR_DOWN), .q(x_out)
  );

  blkmv_ofs #(.W(OFS_W), .DOWN_ONLY(1'b0)) u_yreg (
    .clk(clk), .rst(rst), .load(take), .load_val(y_in),
    .step(at_end), .down(dir_q == DIR_DOWN), .q(y_out)
  );

  blkmv_ofs #(.W(OFS_W), .DOWN_ONLY(1'b1)) u_creg (
    .clk(clk), .rst(rst), .load(take), .load_val(cnt_in),
    .step(at_end), .down(1'b1), .q(cnt_out)
  );

  blkmv_port #(.BANK_W(BANK_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst),
    .at_rd(at_rd), .at_cap(at_cap), .at_wr(at_wr),
    .src_bank(sb_q), .dst_bank(db_q), .src_ofs(x_out), .dst_ofs(y_out),
    .rdata(mem_rdata),
    .addr(mem_addr), .rd(mem_rd), .wr(mem_wr), .wdata(mem_wdata)
  );

  assign busy    = busy_q;
  assign done    = done_q;
  assign dbr_out = dbr_q;

  logic unused_w;
  assign unused_w = ^{ADDR_W};
endmodule

// File: rtl/blkmv_checks.sv
module blkmv_checks #(
  parameter int OFS_W  = 16,
  parameter int BANK_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    busy,
  input logic                    done,
  input logic                    mem_rd,
  input logic                    mem_wr,
  input logic [BANK_W+OFS_W-1:0] mem_addr,
  input logic [OFS_W-1:0]        x_out,
  input logic [OFS_W-1:0]        cnt_out,
  input logic [BANK_W-1:0]       dbr_out
);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd && !mem_wr));

  a_r4_write_after_read: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> $past(mem_rd, 2));

  a_r5_unit_step: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |->
      (x_out == $past(x_out) || x_out == $past(x_out) + 1'b1 || x_out == $past(x_out) - 1'b1));

  a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (cnt_out == $past(cnt_out) || cnt_out == $past(cnt_out) - 1'b1));

  a_r3_done_on_fall: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_dbr_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(dbr_out));

  logic unused_a;
  assign unused_a = ^mem_addr;
endmodule

bind block_move_engine blkmv_checks #(.OFS_W(OFS_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .x_out(x_out), .cnt_out(cnt_out), .dbr_out(dbr_out)
);

// File: tb/sim_block_move_engine.sv
`timescale 1ns/1ps
module sim_block_move_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, dir_dec = 1'b0;
  logic [7:0]  src_bank = '0, dst_bank = '0;
  logic [15:0] x_in = '0, y_in = '0, cnt_in = '0;
  logic        busy, done, mem_rd, mem_wr;
  logic [15:0] x_out, y_out, cnt_out;
  logic [7:0]  dbr_out, mem_wdata, mem_rdata = '0;
  logic [23:0] mem_addr;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  block_move_engine u0 (
    .clk(clk), .rst(rst), .start(start), .dir_dec(dir_dec),
    .src_bank(src_bank), .dst_bank(dst_bank), .x_in(x_in), .y_in(y_in), .cnt_in(cnt_in),
    .busy(busy), .done(done), .x_out(x_out), .y_out(y_out), .cnt_out(cnt_out),
    .dbr_out(dbr_out), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [7:0] mem  [logic [23:0]];
  logic [7:0] refm [logic [23:0]];

  function automatic logic [7:0] seed(logic [23:0] a);
    return a[7:0] ^ {a[10:8], a[15:11]} ^ (a[23:16] * 8'd13) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] rd_mem(logic [23:0] a);
    return mem.exists(a) ? mem[a] : seed(a);
  endfunction
  function automatic logic [7:0] rd_ref(logic [23:0] a);
    return refm.exists(a) ? refm[a] : seed(a);
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= rd_mem(mem_addr);
    if (mem_wr) mem[mem_addr] = mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // address monitor
  logic [7:0]  mon_sb = '0, mon_db = '0;
  logic [15:0] mon_x = '0, mon_y = '0;
  logic        mon_dir = 1'b0;
  int rd_n = 0, wr_n = 0, since_rd = 99;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd) since_rd = 0; else since_rd++;
      if (mem_rd) begin
        logic [15:0] ex;
        ex = mon_dir ? mon_x - 16'(rd_n) : mon_x + 16'(rd_n);
        chk(mem_addr == {mon_sb, ex}, "R4", "read address", mem_addr, {mon_sb, ex});
        rd_n++;
      end
      if (mem_wr) begin
        logic [15:0] ey;
        ey = mon_dir ? mon_y - 16'(wr_n) : mon_y + 16'(wr_n);
        chk(mem_addr == {mon_db, ey}, "R6", "write address in bank", mem_addr, {mon_db, ey});
        chk(since_rd == 2, "R4", "write two cycles after read", since_rd, 2);
        wr_n++;
      end
    end
  end

  task automatic run_move(input logic [7:0] sb, input logic [7:0] db,
                          input logic [15:0] x0, input logic [15:0] y0,
                          input logic [15:0] c, input bit dn,
                          input bit poke, input bit ovl);
    int nb, busy_cyc, done_cyc, k, bad;
    logic [15:0] xs, ys, ex_x, ex_y;
    logic [7:0] snap [int];
    nb = int'(c) + 1;
    xs = x0; ys = y0;
    for (int i = 0; i < nb; i++) begin
      snap[i] = rd_ref({sb, xs});
      refm[{db, ys}] = rd_ref({sb, xs});
      xs = dn ? xs - 1'b1 : xs + 1'b1;
      ys = dn ? ys - 1'b1 : ys + 1'b1;
    end
    ex_x = xs; ex_y = ys;
    @(negedge clk);
    mon_sb = sb; mon_db = db; mon_x = x0; mon_y = y0; mon_dir = dn; rd_n = 0; wr_n = 0;
    src_bank = sb; dst_bank = db; x_in = x0; y_in = y0; cnt_in = c; dir_dec = dn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_cyc = (busy === 1'b1) ? 1 : 0; done_cyc = 0; k = 1;
    while (k < 7 * nb + 20) begin
      if (poke && k == 3) begin
        start = 1'b1; cnt_in = 16'h0000; x_in = 16'h1234; y_in = 16'h4321;
        dir_dec = ~dn; src_bank = 8'hEE; dst_bank = 8'hDD;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (busy) busy_cyc++;
      if (done) begin
        done_cyc++;
        chk(dbr_out == db, "R8", "dbr on done", dbr_out, db);
      end
      k++;
    end
    chk(busy_cyc == 7 * nb, poke ? "R9" : "R3", "busy cycles", busy_cyc, 7 * nb);
    chk(done_cyc == 1, "R3", "done pulse width", done_cyc, 1);
    chk(rd_n == nb && wr_n == nb, "R2", "bytes moved", rd_n, nb);
    chk(cnt_out == 16'hFFFF, "R2", "final count", cnt_out, 16'hFFFF);
    chk(x_out == ex_x, "R5", "final X", x_out, ex_x);
    chk(y_out == ex_y, "R5", "final Y", y_out, ex_y);
    chk(dbr_out == db, "R8", "dbr after", dbr_out, db);
    bad = 0; ys = y0;
    for (int i = 0; i < nb; i++) begin
      if (rd_mem({db, ys}) != rd_ref({db, ys})) bad++;
      if (ovl && rd_mem({db, ys}) != snap[i]) bad++;
      ys = dn ? ys - 1'b1 : ys + 1'b1;
    end
    chk(bad == 0, "R7", "destination contents", bad, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(!busy && !done && !mem_rd && !mem_wr, "R1", "idle strobes", {busy, done, mem_rd, mem_wr}, 0);
    chk(x_out == 0 && y_out == 0 && cnt_out == 0 && dbr_out == 0, "R1", "reset registers",
        {x_out, y_out}, 0);
    // sweep: directions x counts x bank pairs
    for (int d = 0; d < 2; d++)
      for (int ci = 0; ci < 5; ci++)
        for (int bp = 0; bp < 2; bp++) begin
          logic [15:0] cc;
          cc = (ci == 4) ? 16'd9 : 16'(ci);
          run_move(bp ? 8'h03 : 8'h01, bp ? 8'h03 : 8'h02,
                   d ? 16'h0480 : 16'h0400, d ? 16'h2080 : 16'h2000, cc, d[0], 1'b0, 1'b0);
        end
    // R6 wrap upward and downward within the bank
    run_move(8'h10, 8'h11, 16'hFFFD, 16'hFFFE, 16'd4, 1'b0, 1'b0, 1'b0);
    run_move(8'h12, 8'h13, 16'h0002, 16'h0001, 16'd5, 1'b1, 1'b0, 1'b0);
    // R7 overlap: destination above source, decrement from top ends
    run_move(8'h20, 8'h20, 16'h010F, 16'h0113, 16'd15, 1'b1, 1'b0, 1'b1);
    // R7 overlap: destination below source, increment from bottom ends
    run_move(8'h21, 8'h21, 16'h0204, 16'h0200, 16'd15, 1'b0, 1'b0, 1'b1);
    // R9 start pulse during a move is ignored
    run_move(8'h30, 8'h31, 16'h0050, 16'h0060, 16'd6, 1'b0, 1'b1, 1'b0);
    chk(!busy && !mem_rd && !mem_wr, "R10", "quiet after moves", {busy, mem_rd, mem_wr}, 0);
    finish_run();
  end
endmodule